// File: doc/BRIEF.md
# Dual-Port Decoder-Selected Register Bank

The block holds 2^N words of BITS bits each in plain flip-flops. It has one write port and one read port, and both can act in the same clock cycle. On a write, a binary decoder turns the write address into one load enable per row, so only the addressed row loads. On a read, a second decoder picks exactly one row, and only that row reaches the read bus. Each row is gated by its select bit and the gated rows are ORed together. The read word is captured into an output register.

The block is meant for a board with few inputs, so one address input serves both ports. A select bit chooses where each incoming address goes. It goes either into a held read-address register or into a held write-address register, and the other register keeps its value. The write strobe comes from a push-button input. A shift-register conditioner turns one press that is held long enough into a single one-cycle write pulse, however long the button stays down. The default setting is 128 rows of 4 bits with a 7-bit address.

Top module: `dp_regbank_top`

## Requirements
- R1: A write pulse stores `data_w` into the row named by the held write address at the next clock edge. There are 2^N rows, each BITS bits wide, and the bench runs N=7, BITS=4.
- R2: A write changes only the addressed row. Every other row keeps its contents.
- R3: `data_r` is registered. One clock edge after the held read address is loaded, the following edge puts that row's word on `data_r`.
- R4: The row load-enable vector has at most one bit set, and it has exactly one bit set during a write pulse.
- R5: The read-side row select vector always has exactly one bit set.
- R6: When the same row is written and read, `data_r` shows the old word after the write edge and the new word from one edge later. There is no bypass.
- R7: With `addr_is_read`=1, each edge loads `addr_in` into the read address and the write address holds. With `addr_is_read`=0, each edge loads `addr_in` into the write address and the read address holds.
- R8: A press is seen once `we_btn` has been sampled low and then sampled high on PRESS_LEN-1 edges in a row (PRESS_LEN=3 by default). It yields exactly one write pulse, however long the press lasts.
- R9: A press shorter than PRESS_LEN-1 sampled cycles produces no write.
- R10: `rst` (synchronous, active high) clears both held addresses and `data_r` to zero. Row contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | N (7) | Shared address input |
| addr_is_read | input | 1 | 1: address goes to the read side; 0: address goes to the write side |
| data_w | input | BITS (4) | Word to write |
| we_btn | input | 1 | Raw write button level |
| data_r | output | BITS (4) | Registered read word |

## Verification
The assertions assume that `we_btn`, `addr_in` and `addr_is_read` change only between clock edges. They also assume `data_w` is steady at the edge where the write pulse lands. The stimulus meets both assumptions by driving every input on the falling edge. It also leaves `data_w` alone until at least one full cycle after the write edge. Before a row is read back, that row is written with a known word, because rows come out of reset undefined. Between presses the button is held low long enough for the conditioner to see a low level again.

// File: rtl/rf_pkg.sv
package rf_pkg;
  function automatic int row_count(input int addr_bits);
    return 1 << addr_bits;
  endfunction
endpackage

// File: rtl/rf_decoder.sv
module rf_decoder #(
  parameter int N = 7,
  localparam int ROWS = rf_pkg::row_count(N)
) (
  input  logic [N-1:0]    addr,
  input  logic            en,
  output logic [ROWS-1:0] onehot
);
  for (genvar i = 0; i < ROWS; i++) begin : g_dec
    assign onehot[i] = en && (addr == N'(i));
  end
endmodule

// File: rtl/rf_row.sv
module rf_row #(
  parameter int BITS = 4
) (
  input  logic            clk,
  input  logic            ld,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  always_ff @(posedge clk) begin
    if (ld) q <= d;
  end
endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
  parameter int ROWS = 128,
  parameter int BITS = 4
) (
  input  logic [ROWS-1:0]           sel,
  input  logic [ROWS-1:0][BITS-1:0] rows,
  output logic [BITS-1:0]           word
);
  logic [ROWS-1:0][BITS-1:0] gated;

  for (genvar i = 0; i < ROWS; i++) begin : g_gate
    assign gated[i] = rows[i] & {BITS{sel[i]}};
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < ROWS; i++) word = word | gated[i];
  end
endmodule

// File: rtl/rf_addr_demux.sv
module rf_addr_demux #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] addr_in,
  input  logic         to_read,
  output logic [N-1:0] wr_addr,
  output logic [N-1:0] rd_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      rd_addr <= '0;
    end else if (to_read) begin
      rd_addr <= addr_in;
    end else begin
      wr_addr <= addr_in;
    end
  end

  AST_RD_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    to_read |=> rd_addr == $past(addr_in)); // R7
  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    to_read |=> $stable(wr_addr)); // R7
  AST_WR_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
    !to_read |=> wr_addr == $past(addr_in)); // R7
  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !to_read |=> $stable(rd_addr)); // R7
endmodule

// File: rtl/rf_press_pulse.sv
module rf_press_pulse #(
  parameter int PRESS_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic pulse
);
  localparam logic [PRESS_LEN-1:0] MATCH = {{(PRESS_LEN-1){1'b1}}, 1'b0};

  logic [PRESS_LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '1;
    else     hist <= {btn, hist[PRESS_LEN-1:1]};
  end

  assign pulse = (hist == MATCH);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse); // R8
endmodule

// File: rtl/dp_regbank_top.sv
module dp_regbank_top #(
  parameter int N         = 7,
  parameter int BITS      = 4,
  parameter int PRESS_LEN = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    addr_in,
  input  logic            addr_is_read,
  input  logic [BITS-1:0] data_w,
  input  logic            we_btn,
  output logic [BITS-1:0] data_r
);
  localparam int ROWS = rf_pkg::row_count(N);

  logic [N-1:0]              wr_addr, rd_addr;
  logic                      wr_pulse;
  logic [ROWS-1:0]           row_ld, rd_sel;
  logic [ROWS-1:0][BITS-1:0] row_q;
  logic [BITS-1:0]           rd_word;

  rf_addr_demux #(.N(N)) u_demux (
    .clk(clk), .rst(rst), .addr_in(addr_in), .to_read(addr_is_read),
    .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  rf_press_pulse #(.PRESS_LEN(PRESS_LEN)) u_press (
    .clk(clk), .rst(rst), .btn(we_btn), .pulse(wr_pulse)
  );

  rf_decoder #(.N(N)) u_wr_dec (.addr(wr_addr), .en(wr_pulse), .onehot(row_ld));
  rf_decoder #(.N(N)) u_rd_dec (.addr(rd_addr), .en(1'b1),     .onehot(rd_sel));

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    rf_row #(.BITS(BITS)) u_row (
      .clk(clk), .ld(row_ld[i]), .d(data_w), .q(row_q[i])
    );
  end

  rf_read_sel #(.ROWS(ROWS), .BITS(BITS)) u_rsel (
    .sel(rd_sel), .rows(row_q), .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) data_r <= '0;
    else     data_r <= rd_word;
  end

  AST_WR_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_ld)); // R4
  AST_WR_ONEHOT_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> $onehot(row_ld)); // R4
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot(rd_sel)); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> row_q[$past(wr_addr)] == $past(data_w)); // R1
  AST_READ_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> data_r == $past(row_q[rd_addr])); // R3
  AST_NO_LOAD_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (rst)
    !wr_pulse |=> $stable(row_q)); // R2
endmodule

// File: tb/dp_regbank_top_bench.sv
module dp_regbank_top_bench;
  localparam int N = 7;
  localparam int BITS = 4;
  localparam int PL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] addr_in = '0;
  logic addr_is_read = 1'b0;
  logic [BITS-1:0] data_w = '0;
  logic we_btn = 1'b0;
  logic [BITS-1:0] data_r;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dp_regbank_top #(.N(N), .BITS(BITS), .PRESS_LEN(PL)) u_dp_regbank_top (
    .clk(clk), .rst(rst), .addr_in(addr_in), .addr_is_read(addr_is_read),
    .data_w(data_w), .we_btn(we_btn), .data_r(data_r)
  );

  task automatic check(input logic [BITS-1:0] act, input logic [BITS-1:0] exp,
                       input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int cycles);
    @(negedge clk) we_btn = 1'b1;
    idle(cycles);
    we_btn = 1'b0;
    idle(PL + 1);
  endtask

  task automatic write_word(input logic [N-1:0] a, input logic [BITS-1:0] d);
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = a; data_w = d;
    press(PL + 2);
  endtask

  task automatic read_expect(input logic [N-1:0] a, input logic [BITS-1:0] exp,
                             input string req);
    @(negedge clk);
    addr_is_read = 1'b1; addr_in = a;
    idle(2);
    check(data_r, exp, req);
  endtask

  // R10: data_r clears under reset
  task automatic t_reset;
    idle(3);
    check(data_r, '0, "R10 data_r during reset");
    @(negedge clk) rst = 1'b0;
  endtask

  // R1 / R2: basic writes, boundaries, isolation
  task automatic t_basic;
    write_word(7'd0,   4'hA);
    write_word(7'd127, 4'h5);
    write_word(7'd1,   4'h3);
    write_word(7'd2,   4'hC);
    read_expect(7'd0,   4'hA, "R1 row 0");
    read_expect(7'd127, 4'h5, "R1 row 127");
    read_expect(7'd1,   4'h3, "R3 row 1");
    write_word(7'd1,   4'h9);
    read_expect(7'd2,   4'hC, "R2 neighbour untouched");
    read_expect(7'd1,   4'h9, "R1 overwrite");
    read_expect(7'd0,   4'hA, "R2 row 0 untouched");
  endtask

  // R8: long hold writes once; data change later is not stored
  task automatic t_long_hold;
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = 7'd40; data_w = 4'h6;
    @(negedge clk) we_btn = 1'b1;
    idle(PL + 1);
    data_w = 4'hF;
    idle(8);
    we_btn = 1'b0;
    idle(PL + 1);
    read_expect(7'd40, 4'h6, "R8 single pulse on long hold");
    write_word(7'd41, 4'h2);
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = 7'd41; data_w = 4'h7;
    press(PL - 1);
    read_expect(7'd41, 4'h7, "R8 minimum press length writes");
  endtask

  // R9: short press ignored
  task automatic t_glitch;
    write_word(7'd5, 4'h9);
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = 7'd5; data_w = 4'h6;
    press(PL - 2);
    read_expect(7'd5, 4'h9, "R9 short press ignored");
  endtask

  // R7: write address holds while address is steered to read side
  task automatic t_demux;
    write_word(7'd20, 4'h1);
    write_word(7'd30, 4'h4);
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = 7'd30; data_w = 4'hE;
    @(negedge clk);
    addr_is_read = 1'b1; addr_in = 7'd20;
    press(PL + 2);
    check(data_r, 4'h1, "R7 read side follows addr, row 20 untouched");
    read_expect(7'd30, 4'hE, "R7 write went to held write address");
  endtask

  // R6: same-row read during write
  task automatic t_same_row;
    write_word(7'd64, 4'h3);
    @(negedge clk);
    addr_is_read = 1'b0; addr_in = 7'd64; data_w = 4'hB;
    @(negedge clk) addr_is_read = 1'b1;
    @(negedge clk) we_btn = 1'b1;
    idle(PL);
    check(data_r, 4'h3, "R6 old word after write edge");
    idle(1);
    check(data_r, 4'hB, "R6 new word one edge later");
    we_btn = 1'b0;
    idle(PL + 1);
  endtask

  // R10: reset keeps rows, clears read address
  task automatic t_reset_keeps;
    @(negedge clk) rst = 1'b1;
    addr_is_read = 1'b1; addr_in = 7'd64;
    idle(2);
    check(data_r, '0, "R10 data_r cleared");
    rst = 1'b0;
    idle(2);
    check(data_r, 4'hB, "R10 row contents kept");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_long_hold();
    t_glitch();
    t_demux();
    t_same_row();
    t_reset_keeps();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule